// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive side of an I2C target. A fast system clock samples the two bus wires. The block finds START and STOP conditions and shifts in the first frame after each START. It compares the upper seven bits of that frame with a programmable own address. When the address matches and the direction bit asks for a write, the block acknowledges the frame. It then passes the address frame to the host as a throw-away read, and after that it takes in data bytes one by one.

Each complete byte moves from the shift register into a holding register and raises a receive-full flag. The host collects the byte through a one-cycle read strobe, which lowers the flag. If the host has not yet emptied the holding register when the eighth clock of the next byte falls, the block holds SCL low until the read happens. The acknowledge level is set by the host and captured once per frame, so a change made during a frame takes effect only from the following frame.

Both wires are open-drain. The block outputs only pull-low enables and never drives a wire high.

Top module: `i2c_slave_rx`

## Requirements
- R1: After a synchronous reset, rx_full is 0, rx_data is 0, and both scl_pull and sda_pull are 0.
- R2: A frame right after START whose upper seven bits equal own_addr and whose last bit (R/W) is 0 is acknowledged. With ack_level 0, sda_pull is high from the falling edge of the eighth SCL to the falling edge of the ninth, and the wire reads 0 during the ninth high phase. sda_pull is never high outside this acknowledge slot.
- R3: When the address bits differ or R/W is 1, SDA stays released in the ninth slot and nothing is loaded. Every later byte is ignored, with no acknowledge and no load, until the next START.
- R4: After an acknowledged address frame, each data byte is shifted in MSB first. At the rising edge of the ninth SCL it is copied to rx_data and rx_full goes to 1. The address frame itself ({own_addr, 0}) is loaded the same way. A host_rd pulse clears rx_full.
- R5: If rx_full is 1 at the falling edge of the eighth SCL of an acknowledged frame, scl_pull stays high, and rx_data keeps its old byte, until host_rd. If rx_full is 0 at that edge, scl_pull stays low.
- R6: ack_level 0 means pull SDA low in the acknowledge slot, and 1 means release it. The level is captured at the first SCL rise of each frame, so a change made later in a frame applies from the next frame.
- R7: A STOP, or a START in the middle of a frame, returns the engine to waiting for an address. rx_full and rx_data are kept until read. A byte sent after STOP without a new START is ignored.
- R8: The engine responds only while both enable and slave_rx_mode are 1. Otherwise it never pulls either wire low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable |
| slave_rx_mode | input | 1 | Mode select: 1 selects slave receive |
| own_addr | input | 7 | Own 7-bit address |
| ack_level | input | 1 | Acknowledge level: 0 pulls SDA low (ACK), 1 releases it (NACK) |
| host_rd | input | 1 | One-cycle pulse: host has taken rx_data |
| rx_data | output | 8 | Holding register with the last received frame |
| rx_full | output | 1 | Holding register has an unread byte |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |

## Verification
The hardest case to reach is a stretch that coincides with a change of the acknowledge level. One byte has to be left unread while the next one arrives. The host then rewrites ack_level during the stretch, before it reads. The bench runs the bus master and the host as parallel threads to get there: the host thread waits for scl_pull, checks that the old byte is still held, flips ack_level, and then reads. It then confirms that the stretched byte keeps the old acknowledge level and the byte after it uses the new one. The bench also sweeps every 7-bit address and all 256 data values.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    localparam int ADDR_W = 7;
    localparam int FRAME_W = ADDR_W + 1;
    localparam int CNT_W = $clog2(FRAME_W + 1);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_IGNORE
    } srx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic addr_hit(input frame_t frame, input addr_t own);
        return (frame[FRAME_W-1:1] == own) && !frame[0];
    endfunction

endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync
    import i2c_srx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output logic     sda_s,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic scl_q, sda_q, scl_c, sda_c;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else begin
                    scl_chain[g] <= scl_in;
                    sda_chain[g] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else begin
                    scl_chain[g] <= scl_chain[g-1];
                    sda_chain[g] <= sda_chain[g-1];
                end
            end
        end
    end

    assign scl_c = scl_chain[STAGES-1];
    assign sda_c = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    always_comb begin
        evt.start = scl_c && scl_q && sda_q && !sda_c;
        evt.stop  = scl_c && scl_q && !sda_q && sda_c;
        evt.rise  = scl_c && !scl_q;
        evt.fall  = !scl_c && scl_q;
    end

    assign sda_s = sda_c;

    // R7: the bus conditions that end or open a transfer never coincide with an SCL edge
    a_r7_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.start, evt.stop, evt.rise, evt.fall}));

endmodule

// File: rtl/i2c_srx_hold.sv
module i2c_srx_hold
    import i2c_srx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t load_byte,
    input  logic   host_rd,
    output frame_t rx_data,
    output logic   rx_full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (load) begin
            rx_data <= load_byte;
            rx_full <= 1'b1;
        end else if (host_rd) begin
            rx_full <= 1'b0;
        end
    end

    // R4: a host read with no concurrent load empties the register
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !load) |=> !rx_full);

    // R4: a loaded byte is visible and flagged on the next cycle
    a_r4_load_sets: assert property (@(posedge clk) disable iff (rst)
        load |=> (rx_full && rx_data == $past(load_byte)));

    // R5: contents are stable while nothing is loaded
    a_r5_data_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rx_data));

endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
    import i2c_srx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  addr_t    own_addr,
    input  logic     ack_level,
    input  bus_evt_t evt,
    input  logic     sda_s,
    input  logic     rx_full,
    input  logic     host_rd,
    output logic     load,
    output frame_t   load_byte,
    output logic     sda_pull,
    output logic     scl_pull
);

    srx_state_e       state;
    frame_t           shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             ack_lat;
    logic             hit;
    logic             stretch;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    always_comb begin
        load = active && !evt.start && !evt.stop && (state == ST_ACK) && evt.rise;
    end

    assign load_byte = shreg;
    assign scl_pull  = stretch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            ack_lat  <= 1'b0;
            hit      <= 1'b0;
            sda_pull <= 1'b0;
            stretch  <= 1'b0;
        end else if (!active || evt.stop) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            stretch  <= 1'b0;
        end else if (evt.start) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            hit      <= 1'b0;
            sda_pull <= 1'b0;
            stretch  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_DATA: begin
                    if (evt.rise && bitcnt < FULL_CNT) begin
                        shreg  <= {shreg[FRAME_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == '0) ack_lat <= ack_level;
                        if (state == ST_ADDR && bitcnt == LAST_BIT)
                            hit <= addr_hit({shreg[FRAME_W-2:0], sda_s}, own_addr);
                    end else if (evt.fall && bitcnt == FULL_CNT) begin
                        if (state == ST_ADDR && !hit) begin
                            state <= ST_IGNORE;
                        end else begin
                            state    <= ST_ACK;
                            sda_pull <= !ack_lat;
                            stretch  <= rx_full && !host_rd;
                        end
                    end
                end
                ST_ACK: begin
                    if (host_rd) stretch <= 1'b0;
                    if (evt.fall) begin
                        state    <= ST_DATA;
                        bitcnt   <= '0;
                        sda_pull <= 1'b0;
                        stretch  <= 1'b0;
                    end
                end
                ST_IGNORE: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: SDA is only pulled inside the acknowledge slot
    a_r2_pull_in_ack: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> state == ST_ACK);

    // R3: an ignored transfer leaves both wires alone
    a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> (!sda_pull && !scl_pull));

    // R5: SCL is held only while an unread byte occupies the holding register
    a_r5_stretch_needs_full: assert property (@(posedge clk) disable iff (rst)
        scl_pull |-> rx_full);

    // R5: a host read ends the stretch
    a_r5_read_releases: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> !scl_pull);

    // R7: STOP returns to address wait
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> state == ST_IDLE);

    // R8: an inactive engine pulls nothing
    a_r8_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!sda_pull && !scl_pull));

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              slave_rx_mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_level,
    input  logic              host_rd,
    output logic [FRAME_W-1:0] rx_data,
    output logic              rx_full,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull
);

    bus_evt_t evt;
    logic     sda_s;
    logic     load;
    frame_t   load_byte;
    logic     active;

    assign active = enable && slave_rx_mode;

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .sda_s  (sda_s),
        .evt    (evt)
    );

    i2c_srx_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .own_addr  (own_addr),
        .ack_level (ack_level),
        .evt       (evt),
        .sda_s     (sda_s),
        .rx_full   (rx_full),
        .host_rd   (host_rd),
        .load      (load),
        .load_byte (load_byte),
        .sda_pull  (sda_pull),
        .scl_pull  (scl_pull)
    );

    i2c_srx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (load_byte),
        .host_rd   (host_rd),
        .rx_data   (rx_data),
        .rx_full   (rx_full)
    );

endmodule

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;

    localparam int Q = 6;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       en = 1'b0, mode = 1'b0, ackl = 1'b0, host_rd = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [6:0] own = OWN;
    logic [7:0] rx_data;
    logic       rx_full, scl_pull, sda_pull;
    wire        scl_line = scl_m & ~scl_pull;
    wire        sda_line = sda_m & ~sda_pull;

    i2c_slave_rx uut (
        .clk(clk), .rst(rst), .enable(en), .slave_rx_mode(mode),
        .own_addr(own), .ack_level(ackl), .host_rd(host_rd),
        .rx_data(rx_data), .rx_full(rx_full),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    int total = 0, bad = 0, sp_cnt = 0;
    bit done = 0;
    logic ack_a, ack_b;
    logic [7:0] got;

    always @(posedge clk) if (scl_pull) sp_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic v);
        sda_m = v; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackb);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        ackb = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic host_read(output logic [7:0] d);
        @(negedge clk);
        d = rx_data;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1: reset state
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);

        // R8: disabled, then enabled but wrong mode
        bus_start(); send_byte({OWN, 1'b0}, ack_a); bus_stop();
        chk("R8 no ack when disabled", ack_a, 1);
        chk("R8 no load when disabled", rx_full, 0);
        en = 1'b1;
        bus_start(); send_byte({OWN, 1'b0}, ack_a); bus_stop();
        chk("R8 no ack in other mode", ack_a, 1);
        chk("R8 no load in other mode", rx_full, 0);
        mode = 1'b1;

        // R2/R4: address match and full data sweep
        sp_cnt = 0;
        bus_start(); send_byte({OWN, 1'b0}, ack_a);
        chk("R2 address ack", ack_a, 0);
        chk("R4 address loaded flag", rx_full, 1);
        host_read(got);
        chk("R4 dummy read value", got, {OWN, 1'b0});
        tick(1);
        chk("R4 read clears flag", rx_full, 0);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i * 7 + 3);
            send_byte(b, ack_a);
            chk("R4 data ack", ack_a, 0);
            host_read(got);
            chk("R4 data value", got, b);
        end
        chk("R5 no stretch while empty", sp_cnt, 0);
        chk("R2 sda released after slot", sda_pull, 0);
        bus_stop();

        // R3/R2: sweep all addresses
        for (int a = 0; a < 128; a++) begin
            bus_start(); send_byte({7'(a), 1'b0}, ack_a);
            if (7'(a) == OWN) begin
                chk("R2 sweep ack", ack_a, 0);
                host_read(got);
                chk("R2 sweep dummy value", got, {OWN, 1'b0});
            end else begin
                chk("R3 sweep nack", ack_a, 1);
                chk("R3 sweep no load", rx_full, 0);
            end
            bus_stop();
        end

        // R3: read direction and trailing bytes ignored
        bus_start(); send_byte({OWN, 1'b1}, ack_a);
        chk("R3 read dir nack", ack_a, 1);
        send_byte(8'h3C, ack_b);
        chk("R3 trailing byte nack", ack_b, 1);
        chk("R3 trailing byte no load", rx_full, 0);
        bus_stop();
        bus_start(); send_byte({OWN ^ 7'h01, 1'b0}, ack_a);
        send_byte(8'hC3, ack_b);
        chk("R3 mismatch trailing nack", ack_b, 1);
        chk("R3 mismatch no load", rx_full, 0);
        bus_stop();

        // R5/R6: stretch with ack level change during the stretch
        ackl = 1'b0;
        bus_start(); send_byte({OWN, 1'b0}, ack_a); host_read(got);
        send_byte(8'h11, ack_a);
        chk("R4 first byte flagged", rx_full, 1);
        fork
            send_byte(8'h22, ack_b);
            begin
                while (!scl_pull) @(negedge clk);
                tick(50);
                chk("R5 scl held", scl_pull, 1);
                chk("R5 scl line low", scl_line, 0);
                chk("R5 old byte kept", rx_data, 8'h11);
                ackl = 1'b1;
                host_read(got);
                chk("R5 old byte read", got, 8'h11);
                chk("R5 released after read", scl_pull, 0);
            end
        join
        chk("R6 stretched frame keeps old ack", ack_b, 0);
        host_read(got);
        chk("R4 stretched byte value", got, 8'h22);
        send_byte(8'h33, ack_a);
        chk("R6 next frame nack", ack_a, 1);
        host_read(got);
        chk("R6 nacked byte still loaded", got, 8'h33);
        ackl = 1'b0;

        // R7: STOP keeps unread byte, later byte without START ignored
        send_byte(8'h44, ack_a);
        bus_stop();
        tick(10);
        chk("R7 flag kept over stop", rx_full, 1);
        chk("R7 data kept over stop", rx_data, 8'h44);
        send_byte(8'h55, ack_a);
        chk("R7 byte after stop nack", ack_a, 1);
        chk("R7 byte after stop ignored", rx_data, 8'h44);
        host_read(got);
        chk("R7 kept byte read", got, 8'h44);

        // R7: repeated START mid frame
        bus_start(); send_byte({OWN, 1'b0}, ack_a); host_read(got);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start(); send_byte({OWN, 1'b0}, ack_a);
        chk("R7 restart address ack", ack_a, 0);
        host_read(got);
        chk("R7 restart dummy value", got, {OWN, 1'b0});
        send_byte(8'h96, ack_a);
        host_read(got);
        chk("R7 restart data", got, 8'h96);
        bus_stop();

        // R8: disabling mid transfer releases the wires
        bus_start(); send_byte({OWN, 1'b0}, ack_a); host_read(got);
        en = 1'b0;
        send_byte(8'h77, ack_a);
        chk("R8 disabled mid transfer nack", ack_a, 1);
        chk("R8 disabled mid transfer no load", rx_full, 0);
        bus_stop();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule